// File: doc/BRIEF.md
# One-Second Line Performance Monitor

This block counts line code violation strobes that a receive framer raises, grouped into fixed one-second intervals that an external tick marks. A second strobe marks each received bit. At every tick the block copies the interval's violation total into a readable snapshot and resets its running counters. It also classifies the finished second in two ways. The second is errored when it contained any violation. It is severely errored when its violation rate exceeded one per thousand bits.

Software reads the results one byte at a time through a small read port. The 16-bit violation count occupies two byte addresses. Reading either half also copies the other half of the same snapshot into a holding byte at its own address. A later read of that holding byte returns a value that matches the first half, even if a tick has replaced the snapshot in the meantime.

Top module: `lpm_onesec`

## Requirements
- R1: After reset, reads of 0x6D, 0x6E, 0x6F and the holding address 0x70 all return 0x00.
- R2: On a cycle with `sec_tick` high, the number of `err_evt` strobes seen since the previous tick is latched as a 16-bit snapshot. The high byte reads at 0x6E and the low byte at 0x6F. Read data appears on `rd_data` in the cycle after `rd_en`.
- R3: The snapshot and status stay unchanged between ticks, whatever error and bit strobes arrive.
- R4: An `err_evt` or `bit_vld` strobe in the same cycle as `sec_tick` counts toward the new interval, not toward the one being latched.
- R5: The running violation counter saturates at 0xFFFF instead of wrapping.
- R6: Bit 1 of the status byte at 0x6D is 1 exactly when the latched interval held at least one violation.
- R7: Bit 0 of the status byte is 1 exactly when violations×1000 is greater than the interval's bit-strobe count. Equality does not count as severe. The product is formed without overflow.
- R8: Status bits 7 to 2 read as 0, and reads of any address other than 0x6D to 0x70 return 0x00.
- R9: A read of 0x6E copies the snapshot's low byte into the holding byte at 0x70, and a read of 0x6F copies the snapshot's high byte into it. The holding byte keeps that value until the next such read, and later ticks do not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| err_evt | input | 1 | One line code violation this cycle |
| bit_vld | input | 1 | One received bit this cycle |
| sec_tick | input | 1 | One-second interval boundary strobe |
| rd_en | input | 1 | Register read request |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |

## Verification
A one-second tick can arrive in the same cycle as a violation strobe, and also in the same cycle as a register read. The bench provokes the first case by raising `err_evt` and `bit_vld` together with `sec_tick`. It judges the case by checking that the strobe is missing from the latched count and appears in the following snapshot. It provokes the second case by reading the high byte in the tick cycle. It then expects the old high byte, and afterwards reads the holding byte and expects the old low byte.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int LCV_W    = 16;
    localparam int BITS_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 8;
    localparam int PROD_W   = 64;

    localparam logic [ADDR_W-1:0] A_STATUS = 8'h6D;
    localparam logic [ADDR_W-1:0] A_LCV_HI = 8'h6E;
    localparam logic [ADDR_W-1:0] A_LCV_LO = 8'h6F;
    localparam logic [ADDR_W-1:0] A_HOLD   = 8'h70;

    typedef struct packed {
        logic             errsec;
        logic             sevsec;
        logic [LCV_W-1:0] lcv;
    } sec_snap_t;

    // Severity test: errors * den strictly greater than the bit count.
    function automatic logic rate_exceeded(input logic [LCV_W-1:0] errs,
                                           input logic [BITS_W-1:0] bits,
                                           input int unsigned den);
        logic [PROD_W-1:0] prod;
        prod = PROD_W'(errs) * PROD_W'(den);
        return prod > PROD_W'(bits);
    endfunction

endpackage

// File: rtl/lpm_sat_cnt.sv
module lpm_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= inc ? W'(1) : '0;
        end else if (inc && cnt_q != MAXV) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign cnt = cnt_q;

    // R5
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == MAXV && !clr) |=> cnt_q == MAXV);

    // R4
    clr_seed_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt_q == W'($past(inc)));

endmodule

// File: rtl/lpm_interval.sv
module lpm_interval
    import lpm_pkg::*;
#(
    parameter int unsigned RATE_DEN = 1000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      err_evt,
    input  logic      bit_vld,
    input  logic      sec_tick,
    output sec_snap_t snap
);
    logic [LCV_W-1:0]  err_run;
    logic [BITS_W-1:0] bit_run;
    sec_snap_t         snap_q;

    lpm_sat_cnt #(.W(LCV_W)) u_err_cnt (
        .clk (clk),
        .rst (rst),
        .clr (sec_tick),
        .inc (err_evt),
        .cnt (err_run)
    );

    lpm_sat_cnt #(.W(BITS_W)) u_bit_cnt (
        .clk (clk),
        .rst (rst),
        .clr (sec_tick),
        .inc (bit_vld),
        .cnt (bit_run)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
        end else if (sec_tick) begin
            snap_q.lcv    <= err_run;
            snap_q.errsec <= (err_run != '0);
            snap_q.sevsec <= rate_exceeded(err_run, bit_run, RATE_DEN);
        end
    end

    assign snap = snap_q;

    // R3
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sec_tick |=> $stable(snap_q));

    // R6
    errsec_match_chk: assert property (@(posedge clk) disable iff (rst)
        snap_q.errsec == (snap_q.lcv != '0));

    // R7
    sev_implies_err_chk: assert property (@(posedge clk) disable iff (rst)
        snap_q.sevsec |-> snap_q.errsec);

    // R2
    latch_count_chk: assert property (@(posedge clk) disable iff (rst)
        sec_tick |=> snap_q.lcv == $past(err_run));

endmodule

// File: rtl/lpm_rd_port.sv
module lpm_rd_port
    import lpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  sec_snap_t         snap,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] mux_d;

    always_comb begin
        unique case (rd_addr)
            A_STATUS: mux_d = {6'b0, snap.errsec, snap.sevsec};
            A_LCV_HI: mux_d = snap.lcv[15:8];
            A_LCV_LO: mux_d = snap.lcv[7:0];
            A_HOLD:   mux_d = hold_q;
            default:  mux_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            data_q <= '0;
        end else if (rd_en) begin
            data_q <= mux_d;
            if (rd_addr == A_LCV_HI) begin
                hold_q <= snap.lcv[7:0];
            end else if (rd_addr == A_LCV_LO) begin
                hold_q <= snap.lcv[15:8];
            end
        end
    end

    assign rd_data = data_q;

    // R9
    hold_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == A_LCV_HI) |=> hold_q == $past(snap.lcv[7:0]));

    // R9
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && (rd_addr == A_LCV_HI || rd_addr == A_LCV_LO)) |=> $stable(hold_q));

    // R8
    status_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == A_STATUS) |=> data_q[7:2] == 6'b0);

endmodule

// File: rtl/lpm_onesec.sv
module lpm_onesec
    import lpm_pkg::*;
#(
    parameter int unsigned RATE_DEN = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              err_evt,
    input  logic              bit_vld,
    input  logic              sec_tick,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    sec_snap_t snap;

    lpm_interval #(.RATE_DEN(RATE_DEN)) u_interval (
        .clk      (clk),
        .rst      (rst),
        .err_evt  (err_evt),
        .bit_vld  (bit_vld),
        .sec_tick (sec_tick),
        .snap     (snap)
    );

    lpm_rd_port u_rd_port (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .snap    (snap),
        .rd_data (rd_data)
    );

endmodule

// File: tb/lpm_onesec_bench.sv
`timescale 1ns/1ps
module lpm_onesec_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       err_evt = 1'b0;
    logic       bit_vld = 1'b0;
    logic       sec_tick = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_addr = 8'h00;
    logic [7:0] rd_data;

    always #4 clk = ~clk;

    lpm_onesec u_lpm_onesec (
        .clk      (clk),
        .rst      (rst),
        .err_evt  (err_evt),
        .bit_vld  (bit_vld),
        .sec_tick (sec_tick),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       pend_q = 1'b0;

    // bench-side model of interval state
    longint acc_e = 0, acc_b = 0;
    logic [15:0] m_lcv = 16'h0;
    logic        m_es = 1'b0, m_ses = 1'b0;

    always @(posedge clk) pend_q <= rd_en;

    // monitor: compare each read result one cycle after its request
    always @(negedge clk) begin
        if (pend_q && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (rd_data !== e) begin
                n_fail++;
                $display("FAIL %s: got %02h expected %02h", t, rd_data, e);
            end
        end
    end

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
        rd_en = 1'b1;
        rd_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
        rd_addr = 8'h00;
        @(negedge clk);
    endtask

    task automatic drive(input int ne, input int nb);
        for (int i = 0; i < nb; i++) begin
            err_evt = (i < ne);
            bit_vld = 1'b1;
            @(negedge clk);
        end
        err_evt = 1'b0;
        bit_vld = 1'b0;
        acc_e += ne;
        acc_b += nb;
    endtask

    function automatic void latch_model(input bit te, input bit tb);
        longint se;
        se = (acc_e > 65535) ? 65535 : acc_e;
        m_lcv = 16'(se);
        m_es  = (se != 0);
        m_ses = (se * 1000) > acc_b;
        acc_e = te;
        acc_b = tb;
    endfunction

    task automatic tick(input bit te, input bit tb);
        sec_tick = 1'b1;
        err_evt = te;
        bit_vld = tb;
        @(negedge clk);
        sec_tick = 1'b0;
        err_evt = 1'b0;
        bit_vld = 1'b0;
        latch_model(te, tb);
    endtask

    task automatic check_snap(input string t);
        rd(8'h6D, {6'b0, m_es, m_ses}, {t, " R6/R7 status"});
        rd(8'h6E, m_lcv[15:8], {t, " R2 hi"});
        rd(8'h6F, m_lcv[7:0], {t, " R2 lo"});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h6D, 8'h00, "R1 status");
        rd(8'h6E, 8'h00, "R1 hi");
        rd(8'h6F, 8'h00, "R1 lo");
        rd(8'h70, 8'h00, "R1 hold");

        // clean second
        drive(0, 3000); tick(0, 0); check_snap("clean");
        // errored, not severe: 3000 < 5000  (R6)
        drive(3, 5000); tick(0, 0); check_snap("R6 errored");
        // equality boundary: 5000 == 5000 not severe  (R7)
        drive(5, 5000); tick(0, 0); check_snap("R7 equal");
        // severe: 6000 > 5000  (R7)
        drive(6, 5000); tick(0, 0); check_snap("R7 severe");

        // R4: strobes in the tick cycle go to the next interval
        drive(2, 100); tick(1, 1); check_snap("R4 latched");
        tick(0, 0); check_snap("R4 carried");

        // R5 saturation
        drive(70000, 70000); tick(0, 0); check_snap("R5 sat");

        // R9 holding, R3 stability
        drive(291, 400); tick(0, 0); check_snap("R9 base");
        rd(8'h6E, 8'h01, "R9 hi read");
        drive(50, 50);
        tick(0, 0);
        rd(8'h70, 8'h23, "R9 hold low after tick");
        drive(40, 60);
        rd(8'h6F, m_lcv[7:0], "R3 stable lo");
        rd(8'h70, m_lcv[15:8], "R9 hold high after lo read");

        // collision: read high byte in the tick cycle
        drive(837, 900);
        begin
            logic [15:0] old_lcv;
            old_lcv = m_lcv;
            rd_en = 1'b1;
            rd_addr = 8'h6E;
            exp_q.push_back(old_lcv[15:8]);
            tag_q.push_back("R2 hi in tick cycle");
            tick(0, 0);
            rd_en = 1'b0;
            rd_addr = 8'h00;
            @(negedge clk);
            rd(8'h70, old_lcv[7:0], "R9 hold old lo");
            check_snap("R2 new");
        end

        // R8 unmapped addresses
        rd(8'h00, 8'h00, "R8 addr 00");
        rd(8'h71, 8'h00, "R8 addr 71");
        rd(8'h6C, 8'h00, "R8 addr 6C");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule